// File: doc/BRIEF.md
# Serial Port Interrupt Arbiter

This block sits beside the FIFOs and serializers of a serial port controller. It folds every pending interrupt cause into one interrupt request line and a four-bit cause code. The cause code is the low nibble of the identification register that the host reads. The receive path, transmit path and modem-line logic feed it levels and event pulses. The host reaches the block through a small synchronous register bus with one-cycle read and write strobes.

The block owns the state that host accesses change. This is the four-bit enable mask, the sticky overrun and break flags, and the pending flag for "transmit holding register empty". Reading the status register clears the sticky error flags. Reading the identification register while it names the transmit-empty cause retires that cause. Any write of the enable mask while the holding register is empty re-arms it. Each cycle, a fixed five-rank priority chain resolves the qualified causes. The winner is registered as the cause code and as the interrupt level.

Top module: `sio_irq_arbiter`

## Requirements
- R1: After reset, `irq` is 0, `iir_code` is 0x1, the enable mask reads 0, and the overrun, break and transmit-pending flags are clear.
- R2: When several causes are qualified at once, the code shown is the first one in this ranking: line error, receive timeout, receive data, transmit empty, modem change.
- R3: Cause codes are 0x6 line error, 0xC receive timeout, 0x4 receive data, 0x2 transmit empty, 0x0 modem change, and 0x1 when nothing is pending.
- R4: A line-error cause is qualified when enable bit 2 is set and any of overrun, parity error, framing error or break is present.
- R5: A receive timeout is qualified only when enable bit 0 (the receive-data enable) is set. There is no separate enable for it.
- R6: Receive data is qualified when enable bit 0 is set and `rx_ready` is high. With `fifo_on` high, `rx_count` must also be at least the trigger level: `rx_trig_sel` 0/1/2/3 gives 1/4/8/14 bytes.
- R7: A read of address 2 (identification) returns {`fifo_on`,`fifo_on`,2'b00,code} and clears the transmit-pending flag only if the code read is 0x2.
- R8: The transmit-pending flag is set by a rising `thr_empty` or by any write to address 1 (enable mask) while `thr_empty` is high. It is cleared whenever `thr_empty` is low. Modem change (enable bit 3) uses any set bit of `modem_delta`.
- R9: A read of address 5 returns {2'b00,`thr_empty`,break,`rx_frame_err`,`rx_parity_err`,overrun,`rx_ready`}, bits 7 down to 0, and then clears the overrun and break flags. Parity and framing are levels and are not affected.
- R10: The upper nibble of the identification value is 0xC while `fifo_on` is high and 0x0 otherwise.
- R11: `irq` is a registered level, high exactly when `iir_code` is not 0x1. A change on a level input reaches `irq` and `iir_code` at the next clock edge.
- R12: A write to address 1 stores `bus_wdata[3:0]` as the enable mask (bit 0 receive data, bit 1 transmit empty, bit 2 line error, bit 3 modem change). A read of address 1 returns the mask with the upper four bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Read data, registered, valid after the strobe edge |
| err_evt_overrun | input | 1 | Pulse: receive overrun occurred |
| err_evt_break | input | 1 | Pulse: break condition received |
| rx_parity_err | input | 1 | Level: parity error on head character |
| rx_frame_err | input | 1 | Level: framing error on head character |
| rx_ready | input | 1 | Level: receive data available |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig_sel | input | 2 | Receive trigger level select |
| fifo_on | input | 1 | FIFOs enabled |
| rx_timeout | input | 1 | Level: character timeout pending |
| thr_empty | input | 1 | Level: transmit holding register empty |
| modem_delta | input | 4 | Modem line change flags |
| irq | output | 1 | Interrupt request level |
| iir_code | output | 4 | Resolved cause code |

## Verification
A stale or wrong transmit-pending flag shows in two ways. A 0x2 code can persist after the retiring read, or a 0x2 code can fail to return after an enable write. Either is visible within two edges of the access. A sticky error flag that is not cleared keeps code 0x6 on the port two edges after the status read, and the read data also exposes the flag directly. A broken trigger comparison or priority rank changes `iir_code` one edge after the inputs settle. The bench sweeps every enable mask against every cause pattern, and every FIFO count against every trigger setting, so any such fault is visible at the ports.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  localparam int NSRC = 5;

  localparam logic [2:0] ADDR_IER = 3'd1;
  localparam logic [2:0] ADDR_IIR = 3'd2;
  localparam logic [2:0] ADDR_LSR = 3'd5;

  // rank 0 is the highest priority
  function automatic logic [3:0] id_of_rank(input int rank);
    case (rank)
      0:       return ID_LINE;
      1:       return ID_TIMEOUT;
      2:       return ID_RXDATA;
      3:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/sio_irq_state.sv
module sio_irq_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [3:0] ier_wdata,
  input  logic       lsr_rd,
  input  logic       iir_rd_thre,
  input  logic       evt_overrun,
  input  logic       evt_break,
  input  logic       thr_empty,
  output logic [3:0] ier_q,
  output logic       ovr_q,
  output logic       brk_q,
  output logic       thr_pend_q,
  output logic       thr_rise
);
  logic thr_empty_d;

  assign thr_rise = thr_empty & ~thr_empty_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q       <= '0;
      ovr_q       <= 1'b0;
      brk_q       <= 1'b0;
      thr_pend_q  <= 1'b0;
      thr_empty_d <= 1'b0;
    end else begin
      thr_empty_d <= thr_empty;
      if (ier_wr) ier_q <= ier_wdata;
      // a new event in the read cycle survives the clear
      ovr_q <= (ovr_q & ~lsr_rd) | evt_overrun;
      brk_q <= (brk_q & ~lsr_rd) | evt_break;
      if (!thr_empty)                thr_pend_q <= 1'b0;
      else if (ier_wr || thr_rise)   thr_pend_q <= 1'b1;
      else if (iir_rd_thre)          thr_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_irq_srcs.sv
module sio_irq_srcs
  import sio_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [3:0]      ier,
  input  logic [3:0]      line_errs,
  input  logic            rx_ready,
  input  logic [CW-1:0]   rx_count,
  input  logic [1:0]      rx_trig_sel,
  input  logic            fifo_on,
  input  logic            rx_timeout,
  input  logic            thr_pend,
  input  logic [3:0]      modem_delta,
  output logic [NSRC-1:0] req
);
  logic trig_met;

  assign trig_met = !fifo_on || (32'(rx_count) >= trig_bytes(rx_trig_sel));

  assign req[0] = ier[2] & (|line_errs);
  assign req[1] = ier[0] & rx_timeout;
  assign req[2] = ier[0] & rx_ready & trig_met;
  assign req[3] = ier[1] & thr_pend;
  assign req[4] = ier[3] & (|modem_delta);
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [3:0]   code
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_rank
    assign grant[g]   = req[g] & ~taken[g];
    assign taken[g+1] = taken[g] | req[g];
  end

  always_comb begin
    code = ID_NONE;
    for (int i = 0; i < N; i++)
      if (grant[i]) code = id_of_rank(i);
  end
endmodule

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter
  import sio_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata,
  input  logic          err_evt_overrun,
  input  logic          err_evt_break,
  input  logic          rx_parity_err,
  input  logic          rx_frame_err,
  input  logic          rx_ready,
  input  logic [CW-1:0] rx_count,
  input  logic [1:0]    rx_trig_sel,
  input  logic          fifo_on,
  input  logic          rx_timeout,
  input  logic          thr_empty,
  input  logic [3:0]    modem_delta,
  output logic          irq,
  output logic [3:0]    iir_code
);
  // named internal events
  logic            ier_wr, lsr_rd, iir_rd, iir_rd_thre;
  logic [3:0]      ier_q;
  logic            ovr_q, brk_q, thr_pend_q, thr_rise;
  logic [3:0]      line_errs;
  logic [NSRC-1:0] req, grant;
  logic [3:0]      code_next;
  logic            wdata_hi_unused;

  assign wdata_hi_unused = ^bus_wdata[7:4];

  assign ier_wr      = bus_wr & (bus_addr == ADDR_IER);
  assign lsr_rd      = bus_rd & (bus_addr == ADDR_LSR);
  assign iir_rd      = bus_rd & (bus_addr == ADDR_IIR);
  assign iir_rd_thre = iir_rd & (iir_code == ID_THRE);
  assign line_errs   = {brk_q, rx_frame_err, rx_parity_err, ovr_q};

  sio_irq_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_wr      (ier_wr),
    .ier_wdata   (bus_wdata[3:0]),
    .lsr_rd      (lsr_rd),
    .iir_rd_thre (iir_rd_thre),
    .evt_overrun (err_evt_overrun),
    .evt_break   (err_evt_break),
    .thr_empty   (thr_empty),
    .ier_q       (ier_q),
    .ovr_q       (ovr_q),
    .brk_q       (brk_q),
    .thr_pend_q  (thr_pend_q),
    .thr_rise    (thr_rise)
  );

  sio_irq_srcs #(.CW(CW)) u_srcs (
    .ier         (ier_q),
    .line_errs   (line_errs),
    .rx_ready    (rx_ready),
    .rx_count    (rx_count),
    .rx_trig_sel (rx_trig_sel),
    .fifo_on     (fifo_on),
    .rx_timeout  (rx_timeout),
    .thr_pend    (thr_pend_q),
    .modem_delta (modem_delta),
    .req         (req)
  );

  sio_irq_prio #(.N(NSRC)) u_prio (
    .req   (req),
    .grant (grant),
    .code  (code_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iir_code  <= ID_NONE;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      iir_code <= code_next;
      irq      <= (code_next != ID_NONE);
      if (bus_rd) begin
        case (bus_addr)
          ADDR_IER: bus_rdata <= {4'b0000, ier_q};
          ADDR_IIR: bus_rdata <= {{2{fifo_on}}, 2'b00, iir_code};
          ADDR_LSR: bus_rdata <= {2'b00, thr_empty, brk_q, rx_frame_err,
                                  rx_parity_err, ovr_q, rx_ready};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_irq_arbiter_chk.sv
module sio_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       err_evt_overrun,
  input logic       err_evt_break,
  input logic       rx_parity_err,
  input logic       rx_frame_err,
  input logic       thr_empty,
  input logic       thr_rise,
  input logic [3:0] ier_q,
  input logic       ovr_q,
  input logic       brk_q,
  input logic       thr_pend_q,
  input logic [3:0] iir_code
);
  logic line_cause;
  assign line_cause = ier_q[2] & (ovr_q | brk_q | rx_parity_err | rx_frame_err);

  // R3: only the six defined codes ever appear
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    iir_code inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

  // R4 / R2: a line error wins the next code
  a_r4_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    line_cause |=> iir_code == 4'h6);

  // R5: receive-data enable off hides timeout and data
  a_r5_timeout_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_q[0] |=> (iir_code != 4'hC) && (iir_code != 4'h4));

  // R7: retiring read of the transmit-empty cause
  a_r7_thre_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd2 && iir_code == 4'h2 && !thr_rise &&
     !(bus_wr && bus_addr == 3'd1)) |=> !thr_pend_q);

  // R8: enable write re-arms while holding register is empty
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && thr_empty) |=> thr_pend_q);

  // R9: status read clears sticky flags when no new event arrives
  a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5 && !err_evt_overrun && !err_evt_break)
      |=> (!ovr_q && !brk_q));

  // R12: the mask takes the written low nibble
  a_r12_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1) |=> ier_q == $past(bus_wdata[3:0]));
endmodule

bind sio_irq_arbiter sio_irq_arbiter_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_wr          (bus_wr),
  .bus_rd          (bus_rd),
  .err_evt_overrun (err_evt_overrun),
  .err_evt_break   (err_evt_break),
  .rx_parity_err   (rx_parity_err),
  .rx_frame_err    (rx_frame_err),
  .thr_empty       (thr_empty),
  .thr_rise        (thr_rise),
  .ier_q           (ier_q),
  .ovr_q           (ovr_q),
  .brk_q           (brk_q),
  .thr_pend_q      (thr_pend_q),
  .iir_code        (iir_code)
);

// File: tb/sio_irq_arbiter_bench.sv
module sio_irq_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       err_evt_overrun = 1'b0, err_evt_break = 1'b0;
  logic       rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_ready = 1'b0;
  logic [4:0] rx_count = '0;
  logic [1:0] rx_trig_sel = '0;
  logic       fifo_on = 1'b0, rx_timeout = 1'b0, thr_empty = 1'b0;
  logic [3:0] modem_delta = '0;
  logic       irq;
  logic [3:0] iir_code;

  int nvec = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sio_irq_arbiter u_sio_irq_arbiter (.*);

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [3:0] model_code(input logic [3:0] ier, input bit line,
      input bit tmo, input bit rdy_ok, input bit thrp, input bit dlt);
    if (ier[2] && line)        return 4'h6;
    else if (ier[0] && tmo)    return 4'hC;
    else if (ier[0] && rdy_ok) return 4'h4;
    else if (ier[1] && thrp)   return 4'h2;
    else if (ier[3] && dlt)    return 4'h0;
    return 4'h1;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h6: return "R4";
      4'hC: return "R5";
      4'h4: return "R6";
      4'h2: return "R8";
      4'h0: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [3:0] e;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 code", {4'd0, iir_code}, 8'h01);
    rd_reg(3'd1, d); check("R1 mask", d, 8'h00);
    rd_reg(3'd5, d); check("R1 status", d, 8'h00);

    // Sweep: every mask against every cause pattern (R2 R3 R4 R5 R8 R11)
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 32; p++) begin
        thr_empty = 0; rx_parity_err = 0; rx_timeout = 0; rx_ready = 0; modem_delta = 0;
        tick();
        wr_reg(3'd1, 8'(m));
        rx_parity_err = p[0]; rx_timeout = p[1]; rx_ready = p[2];
        thr_empty = p[3]; modem_delta = p[4] ? 4'b0100 : 4'b0000;
        tick(); tick();
        e = model_code(4'(m), p[0], p[1], p[2], p[3], p[4]);
        check(tag_of(e), {4'd0, iir_code}, {4'd0, e});
        check("R11 level", {7'd0, irq}, {7'd0, e != 4'h1});
      end
    end
    thr_empty = 0; rx_parity_err = 0; rx_timeout = 0; rx_ready = 0; modem_delta = 0;
    tick();

    // Sweep: trigger qualification R6
    wr_reg(3'd1, 8'h01);
    rx_ready = 1;
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c <= 16; c++) begin
          int lvl;
          fifo_on = f[0]; rx_trig_sel = 2'(s); rx_count = 5'(c);
          tick(); tick();
          lvl = (s == 0) ? 1 : (s == 3) ? 14 : 4 * s;
          e = (f == 0 || c >= lvl) ? 4'h4 : 4'h1;
          check("R6 trigger", {4'd0, iir_code}, {4'd0, e});
        end
    rx_ready = 0; fifo_on = 0; rx_count = 0; rx_trig_sel = 0;
    tick(); tick();

    // R11 one-edge latency
    rx_timeout = 1; tick();
    check("R11 rise", {3'd0, irq, iir_code}, 8'h1C);
    rx_timeout = 0; tick();
    check("R11 fall", {3'd0, irq, iir_code}, 8'h01);

    // R7 retiring read
    thr_empty = 1; wr_reg(3'd1, 8'h02); tick();
    check("R7 armed", {4'd0, iir_code}, 8'h02);
    rd_reg(3'd2, d); check("R7 read value", d, 8'h02);
    tick();
    check("R7 retired", {3'd0, irq, iir_code}, 8'h01);
    rx_ready = 1; wr_reg(3'd1, 8'h03); tick();
    check("R7 data first", {4'd0, iir_code}, 8'h04);
    rd_reg(3'd2, d); check("R7 read other", d, 8'h04);
    rx_ready = 0; tick(); tick();
    check("R7 kept", {4'd0, iir_code}, 8'h02);
    // R8 empty low clears, rise sets
    thr_empty = 0; tick(); tick();
    check("R8 cleared", {4'd0, iir_code}, 8'h01);
    thr_empty = 1; tick(); tick();
    check("R8 rise", {4'd0, iir_code}, 8'h02);
    thr_empty = 0; tick();

    // R9 sticky flags
    wr_reg(3'd1, 8'h04);
    err_evt_overrun = 1; tick(); err_evt_overrun = 0; tick();
    check("R9 overrun", {4'd0, iir_code}, 8'h06);
    rd_reg(3'd5, d); check("R9 overrun read", d, 8'h02);
    tick();
    check("R9 overrun clear", {4'd0, iir_code}, 8'h01);
    err_evt_break = 1; tick(); err_evt_break = 0; tick();
    rd_reg(3'd5, d); check("R9 break read", d, 8'h10);
    tick();
    check("R9 break clear", {4'd0, iir_code}, 8'h01);
    rx_frame_err = 1; tick();
    check("R4 framing", {4'd0, iir_code}, 8'h06);
    rd_reg(3'd5, d); check("R9 framing read", d, 8'h08);
    tick();
    check("R9 framing level kept", {4'd0, iir_code}, 8'h06);
    rx_frame_err = 0; tick();

    // R10 upper nibble
    fifo_on = 1; tick();
    rd_reg(3'd2, d); check("R10 fifo on", d, 8'hC1);
    fifo_on = 0; tick();
    rd_reg(3'd2, d); check("R10 fifo off", d, 8'h01);

    // R12 mask readback
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, d); check("R12 mask", d, 8'h0F);
    wr_reg(3'd1, 8'hA5);
    rd_reg(3'd1, d); check("R12 mask", d, 8'h05);

    finish_run();
  end
endmodule